// File: doc/BRIEF.md
# HDLC Inter-frame Flag Generator

This block drives the serial transmit line of an HDLC link in the gaps between frames. One bit leaves on every clock. A frame source raises a ready signal when it holds a frame. The block then sends opening flags until a programmable minimum count is met. After that it raises a take strobe, and while the strobe is high the source presents one data bit per cycle along with an end-of-frame marker. The block passes those data bits straight to the line. Once the last bit is out, the block appends a closing flag.

Between frames the line either repeats flags or rests at all ones, as chosen by an idle-mode input. A 4-bit setting gives the minimum number of opening flags:

- **Setting of zero:** at least one flag, and the closing flag of one frame may act as the opening flag of the next.
- **Nonzero setting N:** at least N flags precede every frame. The closing flag does not count toward N, so two frames sent back to back always have N flags between them.

Bit stuffing and CRC belong to the source.

Top module: `hdlc_ifg_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `tx_bit` is 1 and `frm_take` is 0.
- R2: A flag is the octet 0x7E sent least significant bit first, giving the line sequence 0,1,1,1,1,1,1,0.
- R3: With `idle_mark` = 0 and no frame pending, the line repeats complete flags continuously and `frm_take` stays 0.
- R4: With `idle_mark` = 1 and no frame pending, every bit after the closing flag is 1. From that idle state, a frame is preceded by a fresh set of opening flags.
- R5: With `min_flags` = 0, a frame is preceded by at least one flag. When a frame is pending at the end of the closing flag of the previous frame, `frm_take` is low for exactly 8 cycles between the two frames.
- R6: With `min_flags` = N > 0, at least N opening flags precede every frame, and the closing flag is not counted. Back-to-back frames are separated by exactly N+1 flags, which means `frm_take` is low for 8·(N+1) cycles.
- R7: `frm_take` rises only in the cycle right after the last bit of a complete flag.
- R8: A data bit presented in a cycle where `frm_take` is 1 appears on `tx_bit` one cycle later. `frm_take` stays high for exactly as many cycles as the frame has bits.
- R9: The cycle after `frm_last` is presented with `frm_take` high, a closing flag starts, and all eight of its bits are sent.
- R10: `frm_ready` has no effect while a frame is being sent: the data phase continues until `frm_last`, even if `frm_ready` drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| min_flags | input | 4 | Minimum opening-flag count (0 means shared closing/opening flag) |
| idle_mark | input | 1 | 1: idle at all ones; 0: idle with repeated flags |
| frm_ready | input | 1 | Source holds a frame to send |
| frm_data | input | 1 | Data bit, valid when `frm_take` is 1 |
| frm_last | input | 1 | Marks the final data bit, valid when `frm_take` is 1 |
| frm_take | output | 1 | Block consumes `frm_data`/`frm_last` this cycle |
| tx_bit | output | 1 | Serial line output |

## Verification
The hardest situation to reach is the handover at the end of a closing flag. A new frame must already be pending at that point, so that the flag sharing (zero setting) or the counted separation (nonzero setting) takes effect instead of idle. The stimulus queues several frames before the first one starts. The source model then keeps `frm_ready` high through each frame's last bit, so every following frame is pending when its predecessor's closing flag ends. The gap in `frm_take` is measured under both settings and both idle modes. A separate run drops `frm_ready` partway through a frame to show that the data phase still runs to its end.

// File: rtl/hdlc_ifg_pkg.sv
package hdlc_ifg_pkg;

  // Line activity currently being emitted.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,   // mark idle: constant ones
    PH_FLAG = 2'd1,   // one flag octet in progress
    PH_DATA = 2'd2    // frame data pass-through
  } phase_e;

endpackage

// File: rtl/hdlc_ifg_count.sv
// Opening-flag counter and the "enough flags" decision.
module hdlc_ifg_count #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,        // restart count (mark idle)
  input  logic             flag_done,  // a flag octet completes this cycle
  input  logic             closing,    // the completing flag is a closing flag
  input  logic [CNT_W-1:0] min_flags,
  output logic             enough      // count after this flag meets the minimum
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;
  logic [CNT_W-1:0] need;
  logic             shared;

  // A zero setting means one flag, and the closing flag may supply it.
  assign shared = (min_flags == '0);
  assign need   = shared ? CNT_ONE : min_flags;

  always_comb begin
    if (closing)
      cnt_next = shared ? CNT_ONE : '0;
    else if (cnt_q == CNT_MAX)
      cnt_next = cnt_q;
    else
      cnt_next = cnt_q + CNT_ONE;
  end

  assign enough = (cnt_next >= need);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (flag_done)
      cnt_q <= cnt_next;
  end

  // R6: leaving mark idle restarts the opening-flag count
  p_clear_restarts_r6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));

  // R6: a closing flag under a nonzero setting leaves the count at zero
  p_closing_not_counted_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_done && closing && !clr && min_flags != '0) |=> (cnt_q == '0));

endmodule

// File: rtl/hdlc_ifg_seq.sv
// Line sequencer: idle, flag octets, data pass-through.
module hdlc_ifg_seq
  import hdlc_ifg_pkg::*;
#(
  parameter int FLAG_LEN = 8,
  localparam int BIDX_W  = $clog2(FLAG_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_ready,
  input  logic              frm_last,
  input  logic              idle_mark,
  input  logic              enough,
  output phase_e            phase,
  output logic [BIDX_W-1:0] bidx,
  output logic              closing,
  output logic              flag_done,
  output logic              clr,
  output logic              take
);

  localparam logic [BIDX_W-1:0] BIDX_END = BIDX_W'(FLAG_LEN - 1);

  phase_e            ph_q, ph_d;
  logic [BIDX_W-1:0] bidx_q, bidx_d;
  logic              clos_q, clos_d;
  logic              take_q;

  assign flag_done = (ph_q == PH_FLAG) && (bidx_q == BIDX_END);
  assign clr       = (ph_q == PH_IDLE);

  always_comb begin
    ph_d   = ph_q;
    bidx_d = bidx_q;
    clos_d = clos_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (frm_ready || !idle_mark) begin
          ph_d   = PH_FLAG;
          bidx_d = '0;
          clos_d = 1'b0;
        end
      end
      PH_FLAG: begin
        if (!flag_done) begin
          bidx_d = bidx_q + 1'b1;
        end else if (frm_ready && enough) begin
          ph_d = PH_DATA;
        end else if (idle_mark && !frm_ready) begin
          ph_d = PH_IDLE;
        end else begin
          bidx_d = '0;
          clos_d = 1'b0;
        end
      end
      PH_DATA: begin
        if (frm_last) begin
          ph_d   = PH_FLAG;
          bidx_d = '0;
          clos_d = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      bidx_q <= '0;
      clos_q <= 1'b0;
      take_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      bidx_q <= bidx_d;
      clos_q <= clos_d;
      take_q <= (ph_d == PH_DATA);
    end
  end

  assign phase   = ph_q;
  assign bidx    = bidx_q;
  assign closing = clos_q;
  assign take    = take_q;

  // R7: data starts only right after a complete flag that met the count
  p_start_on_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_FLAG && !flag_done) |=> (ph_q != PH_DATA));

  p_start_needs_count_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_done && !enough) |=> (ph_q != PH_DATA));

  // R9: end of frame is followed by a closing flag from its first bit
  p_closing_follows_r9: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_DATA && frm_last) |=> (ph_q == PH_FLAG && bidx_q == '0 && clos_q));

  // R10: the data phase holds until the last bit whatever frm_ready does
  p_data_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_DATA && !frm_last) |=> (ph_q == PH_DATA));

endmodule

// File: rtl/hdlc_ifg_txbit.sv
// Selects the line bit for the current slot and registers it.
module hdlc_ifg_txbit
  import hdlc_ifg_pkg::*;
#(
  parameter int               FLAG_LEN = 8,
  parameter logic [FLAG_LEN-1:0] FLAG_PAT = 8'h7E,
  localparam int              BIDX_W   = $clog2(FLAG_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            phase,
  input  logic [BIDX_W-1:0] bidx,
  input  logic              data_bit,
  output logic              tx_bit
);

  logic cur_bit;
  logic tx_q;

  always_comb begin
    unique case (phase)
      PH_FLAG: cur_bit = FLAG_PAT[bidx];   // LSB first
      PH_DATA: cur_bit = data_bit;
      default: cur_bit = 1'b1;             // mark
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      tx_q <= 1'b1;
    else
      tx_q <= cur_bit;
  end

  assign tx_bit = tx_q;

  // R4: a mark-idle slot puts a one on the line
  p_mark_is_one_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |=> tx_q);

  // R8: a data slot shows the presented bit one cycle later
  p_data_passes_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA) |=> (tx_q == $past(data_bit)));

  // R2: the first bit of every flag is a zero
  p_flag_opens_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FLAG && bidx == '0) |=> !tx_q);

endmodule

// File: rtl/hdlc_ifg_gen.sv
module hdlc_ifg_gen
  import hdlc_ifg_pkg::*;
#(
  parameter int                  CNT_W    = 4,
  parameter int                  FLAG_LEN = 8,
  parameter logic [FLAG_LEN-1:0] FLAG_PAT = 8'h7E
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] min_flags,
  input  logic             idle_mark,
  input  logic             frm_ready,
  input  logic             frm_data,
  input  logic             frm_last,
  output logic             frm_take,
  output logic             tx_bit
);

  localparam int BIDX_W = $clog2(FLAG_LEN);

  phase_e            phase;
  logic [BIDX_W-1:0] bidx;
  logic              closing;
  logic              flag_done;
  logic              clr;
  logic              enough;

  hdlc_ifg_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .flag_done (flag_done),
    .closing   (closing),
    .min_flags (min_flags),
    .enough    (enough)
  );

  hdlc_ifg_seq #(.FLAG_LEN(FLAG_LEN)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .frm_ready (frm_ready),
    .frm_last  (frm_last),
    .idle_mark (idle_mark),
    .enough    (enough),
    .phase     (phase),
    .bidx      (bidx),
    .closing   (closing),
    .flag_done (flag_done),
    .clr       (clr),
    .take      (frm_take)
  );

  hdlc_ifg_txbit #(.FLAG_LEN(FLAG_LEN), .FLAG_PAT(FLAG_PAT)) u_txbit (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .bidx     (bidx),
    .data_bit (frm_data),
    .tx_bit   (tx_bit)
  );

  // R1: the line is marked and no data is taken just after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (tx_bit && !frm_take));

endmodule

// File: tb/hdlc_ifg_gen_bench.sv
module hdlc_ifg_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] min_flags = 4'd0;
  logic       idle_mark = 1'b0;
  logic       frm_ready = 1'b0;
  logic       frm_data  = 1'b0;
  logic       frm_last  = 1'b0;
  logic       frm_take;
  logic       tx_bit;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_ifg_gen u_hdlc_ifg_gen (
    .clk(clk), .rst(rst), .min_flags(min_flags), .idle_mark(idle_mark),
    .frm_ready(frm_ready), .frm_data(frm_data), .frm_last(frm_last),
    .frm_take(frm_take), .tx_bit(tx_bit)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // ---------------- frame source ----------------
  int  fq[$];          // pending frame lengths
  int  rem = 0;        // bits still to give from current frame
  bit  kill = 0;       // force frm_ready low (R10 test)
  bit  cmp_en = 0;

  // ---------------- reference model ----------------
  // m_ph: 0 mark idle, 1 flag, 2 data
  int  m_ph = 0, m_pos = 0, m_gap = 0;
  bit  m_close = 0;
  bit  exp_tx = 1, exp_take = 0;
  string exp_tag = "R1";

  function automatic int flag_bit(input int p);
    return (p == 0 || p == 7) ? 0 : 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_pos = 0; m_gap = 0; m_close = 0;
      exp_tx = 1; exp_take = 0; exp_tag = "R1";
    end else begin
      int need;
      need = (min_flags == 0) ? 1 : int'(min_flags);
      case (m_ph)
        0: begin
          exp_tx = 1; exp_tag = "R4"; m_gap = 0;
          if (frm_ready || !idle_mark) begin m_ph = 1; m_pos = 0; m_close = 0; end
        end
        1: begin
          exp_tx = flag_bit(m_pos); exp_tag = "R2";
          if (m_pos < 7) m_pos++;
          else begin
            if (m_close) m_gap = (min_flags == 0) ? 1 : 0;
            else if (m_gap < 15) m_gap++;
            if (frm_ready && m_gap >= need) m_ph = 2;
            else if (idle_mark && !frm_ready) m_ph = 0;
            else begin m_pos = 0; m_close = 0; end
          end
        end
        default: begin
          exp_tx = frm_data; exp_tag = "R8";
          if (frm_last) begin m_ph = 1; m_pos = 0; m_close = 1; end
        end
      endcase
      exp_take = (m_ph == 2);
    end
  end

  // ---------------- monitors on the falling edge ----------------
  bit prev_take = 0;
  int low_run = 0, hi_run = 0, last_gap = -1, last_len = -1;
  int after_fall = -1;
  logic [7:0] close_oct;
  int ones_run = 0, max_ones = 0;

  always @(negedge clk) begin
    cycles++;
    if (cmp_en) begin
      check({exp_tag, " line bit"}, tx_bit, exp_tx);
      check("R7 take", frm_take, exp_take);
      // run lengths of frm_take
      if (prev_take && !frm_take) begin last_len = hi_run; low_run = 0; after_fall = 0; end
      if (!prev_take && frm_take) begin last_gap = low_run; hi_run = 0; end
      if (frm_take) hi_run++; else low_run++;
      // closing flag capture: bits at offsets 1..8 after the fall
      if (after_fall >= 1 && after_fall <= 8) close_oct = {tx_bit, close_oct[7:1]};
      if (after_fall == 8) check("R9 closing flag", close_oct, 8'h7E);
      if (after_fall >= 0 && after_fall <= 8) after_fall++;
      if (tx_bit) ones_run++; else ones_run = 0;
      if (ones_run > max_ones) max_ones = ones_run;
      prev_take = frm_take;
    end
    // drive source for this cycle
    if (frm_take && rem > 0) begin
      frm_data = ($urandom_range(1) == 1);
      frm_last = (rem == 1);
      rem--;
    end else begin
      frm_data = 0; frm_last = 0;
      if (rem == 0 && fq.size() > 0) rem = fq.pop_front();
    end
    frm_ready = ((rem > 0) || (fq.size() > 0)) && !kill;
  end

  // ---------------- watchdog ----------------
  initial begin
    wait (cycles > WATCHDOG);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic drain();
    while (rem > 0 || fq.size() > 0 || frm_take) @(negedge clk);
    run(10);
  endtask

  initial begin
    run(3);
    check("R1 reset tx", tx_bit, 1);
    check("R1 reset take", frm_take, 0);
    rst = 0;
    @(negedge clk);
    cmp_en = 1;
    check("R1 first cycle tx", tx_bit, 1);
    check("R1 first cycle take", frm_take, 0);

    // R3: flag idle, no frames
    max_ones = 0;
    run(48);
    check("R3 no six+ ones run", (max_ones <= 6) ? 1 : 0, 1);
    check("R3 take low", frm_take, 0);

    // R5: zero setting, back-to-back frames share flag
    min_flags = 0;
    fq.push_back(13); fq.push_back(9);
    drain();
    check("R5 gap cycles", last_gap, 8);
    check("R8 frame length", last_len, 9);

    // R6: setting 3, separation of closing + 3 flags
    min_flags = 3;
    fq.push_back(10); fq.push_back(7);
    drain();
    check("R6 gap cycles", last_gap, 32);
    check("R8 frame length", last_len, 7);

    // R4: mark idle, then a frame from idle with setting 2
    idle_mark = 1; min_flags = 2;
    run(8);
    max_ones = 0; ones_run = 0;
    run(30);
    check("R4 mark ones", tx_bit, 1);
    check("R4 ones run", (max_ones >= 30) ? 1 : 0, 1);
    fq.push_back(11);
    drain();
    check("R8 frame length", last_len, 11);

    // R5 in mark mode: back-to-back share the closing flag
    min_flags = 0;
    fq.push_back(6); fq.push_back(12);
    drain();
    check("R5 mark gap cycles", last_gap, 8);

    // R10: frm_ready dropped in mid frame
    min_flags = 1;
    fq.push_back(20);
    while (!frm_take) @(negedge clk);
    run(5);
    kill = 1;
    drain();
    kill = 0;
    check("R10 length despite ready low", last_len, 20);

    // R6 with larger count, flag idle
    idle_mark = 0; min_flags = 5;
    fq.push_back(4); fq.push_back(5);
    drain();
    check("R6 gap cycles N=5", last_gap, 48);

    run(20);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule